// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Controller

This block is the memory-side end of a three-wire serial memory link (chip select, serial clock, data in, data out). Every pin is sampled with the block's own system clock, and rising edges of the serial clock are found inside the block. Each frame opens after chip select goes high. Zeros are skipped until a 1 arrives as the start bit. A two-bit operation code and a word address follow, most significant bit first. The operations are reading one word, writing one word, erasing one word, filling every word with a supplied pattern, erasing every word, and setting or clearing a write-enable latch.

Storage is a register array of 2^ADDR_W words of DATA_W bits. A change to the array waits for a self-timed programming cycle of PROG_CYCLES system clocks and is committed when that cycle ends. The write-enable latch comes out of reset cleared, so the host must enable programming before any change can land. A host learns that a cycle has ended by dropping chip select and raising it again, then watching the data-out pin. While the block is busy, any new frame is ignored.

Top module: `serialEeprom`

## Requirements
- R1: Serial-clock rises while the data-in pin is 0 before the start bit are ignored. A frame is a start bit of 1, a 2-bit opcode and then ADDR_W address bits, each sent MSB first and sampled on serial-clock rising edges.
- R2: Opcode 10 is READ. The block enables data-out and shows a dummy 0 first. Each later serial-clock rise then shifts out the addressed word MSB first. This works whatever the state of the write-enable latch.
- R3: After reset the write-enable latch is cleared. WRITE, ERASE, fill-all and erase-all then leave the array unchanged and start no busy cycle.
- R4: Opcode 00 with the top two address bits 11 sets the write-enable latch. Opcode 00 with those bits 00 clears it again, after which programming is refused once more.
- R5: Opcode 01 is WRITE. DATA_W data bits follow the address, MSB first. The cycle starts after the last data bit, and the word is stored when the cycle completes.
- R6: Opcode 11 is ERASE. It sets the addressed word to all ones, and its cycle starts as soon as the address is decoded.
- R7: Opcode 00 with the top address bits 01 is fill-all: a data word follows, and it is written to every location. Opcode 00 with the top address bits 10 is erase-all: every word becomes all ones.
- R8: If chip select goes low and then high again while a cycle is running, data-out is enabled and reads 0. It reads 1 once the PROG_CYCLES-clock cycle has completed.
- R9: If chip select is raised again only after the cycle has finished, data-out stays disabled (no status is shown).
- R10: A frame received while a cycle is running is ignored and does not change the array.
- R11: While chip select is low, data-out is disabled and driven 0. Dropping chip select partway through a frame abandons that frame.
- R12: After reset data-out is disabled and every word of the array reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csIn | input | 1 | Chip select, active high |
| skIn | input | 1 | Serial clock from the host |
| diIn | input | 1 | Serial data in |
| doOut | output | 1 | Serial data out (0 when not enabled) |
| doEn | output | 1 | Data-out drive enable |

## Verification
The bench targets five corner cases:
- Programming attempted before the latch is enabled, and again after it is cleared. A design that ignored the latch would change stored words.
- A read's leading dummy bit. A design that dropped it would return the word shifted by one bit.
- A status poll during the cycle, a poll after the cycle, and a frame sent mid-cycle. Faulty handling would show ready too early, present status after completion, or let the mid-cycle frame overwrite a word.
- A write abandoned halfway by dropping chip select. A design that kept partial data would store it.
- Fill-all and erase-all, checked at the lowest and highest addresses to catch a partial sweep of the array.

// File: rtl/serialEepromPkg.sv
package serialEepromPkg;
  localparam logic [1:0] OP_SPECIAL = 2'b00;
  localparam logic [1:0] OP_WRITE   = 2'b01;
  localparam logic [1:0] OP_READ    = 2'b10;
  localparam logic [1:0] OP_ERASE   = 2'b11;

  localparam logic [1:0] GRP_WEOFF  = 2'b00;
  localparam logic [1:0] GRP_FILL   = 2'b01;
  localparam logic [1:0] GRP_CLRALL = 2'b10;
  localparam logic [1:0] GRP_WEON   = 2'b11;

  typedef struct packed {
    logic bitIn;
    logic shiftAddr;
    logic shiftData;
    logic loadOut;
    logic shiftOut;
    logic commit;
    logic commitAll;
    logic fillOnes;
  } eeStrobes_t;
endpackage

// File: rtl/serialEepromCtrl.sv
module serialEepromCtrl
  import serialEepromPkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 400
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csIn,
  input  logic       skIn,
  input  logic       diIn,
  output eeStrobes_t strb,
  output logic       busy,
  output logic       weLatch,
  output logic       pollActive,
  output logic       ctrlDoEn
);
  localparam int MAXW  = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
  localparam int CNT_W = $clog2(MAXW) + 1;
  localparam int TMR_W = $clog2(PROG_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_OPC, S_ADDR, S_DATA, S_LOAD, S_READ, S_DONE} state_t;

  state_t           state;
  logic             csQ, csPrev, skQ, skPrev, diQ;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       opcode;
  logic [1:0]       grp;
  logic [TMR_W-1:0] tmr;
  logic             progAll, progErase;

  logic skRise, csRise, lastAddr, lastData;
  logic startProg, nxtAll, nxtErase, weSet, weClr, commitNow;

  assign skRise    = csQ & skQ & ~skPrev;
  assign csRise    = csQ & ~csPrev;
  assign lastAddr  = (state == S_ADDR) && skRise && (cnt == CNT_W'(ADDR_W - 1));
  assign lastData  = (state == S_DATA) && skRise && (cnt == CNT_W'(DATA_W - 1));
  assign commitNow = busy && (tmr == '0);

  always_comb begin
    startProg = 1'b0;
    nxtAll    = 1'b0;
    nxtErase  = 1'b0;
    weSet     = 1'b0;
    weClr     = 1'b0;
    if (lastAddr) begin
      if (opcode == OP_ERASE) begin
        startProg = weLatch;
        nxtErase  = 1'b1;
      end else if (opcode == OP_SPECIAL) begin
        case (grp)
          GRP_WEOFF:  weClr = 1'b1;
          GRP_WEON:   weSet = 1'b1;
          GRP_CLRALL: begin
            startProg = weLatch;
            nxtAll    = 1'b1;
            nxtErase  = 1'b1;
          end
          default: ;
        endcase
      end
    end
    if (lastData) begin
      startProg = weLatch;
      nxtAll    = (opcode == OP_SPECIAL);
    end
  end

  always_comb begin
    strb           = '0;
    strb.bitIn     = diQ;
    strb.shiftAddr = (state == S_ADDR) && skRise;
    strb.shiftData = (state == S_DATA) && skRise;
    strb.loadOut   = (state == S_LOAD);
    strb.shiftOut  = (state == S_READ) && skRise;
    strb.commit    = commitNow;
    strb.commitAll = progAll;
    strb.fillOnes  = progErase;
  end

  assign ctrlDoEn = csQ & (pollActive | (state == S_READ));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csQ <= 1'b0; csPrev <= 1'b0; skQ <= 1'b0; skPrev <= 1'b0; diQ <= 1'b0;
    end else begin
      csQ <= csIn; csPrev <= csQ; skQ <= skIn; skPrev <= skQ; diQ <= diIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      cnt        <= '0;
      opcode     <= '0;
      grp        <= '0;
      pollActive <= 1'b0;
    end else if (!csQ) begin
      state      <= S_IDLE;
      pollActive <= 1'b0;
    end else begin
      if (csRise && busy) pollActive <= 1'b1;
      case (state)
        S_IDLE: if (skRise && diQ && !busy) begin
          state      <= S_OPC;
          cnt        <= '0;
          pollActive <= 1'b0;
        end
        S_OPC: if (skRise) begin
          opcode <= {opcode[0], diQ};
          if (cnt == CNT_W'(1)) begin
            state <= S_ADDR;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_ADDR: if (skRise) begin
          if (cnt == CNT_W'(0)) grp[1] <= diQ;
          if (cnt == CNT_W'(1)) grp[0] <= diQ;
          cnt <= cnt + 1'b1;
          if (lastAddr) begin
            cnt <= '0;
            if (opcode == OP_READ) state <= S_LOAD;
            else if (opcode == OP_WRITE || (opcode == OP_SPECIAL && grp == GRP_FILL)) state <= S_DATA;
            else state <= S_DONE;
          end
        end
        S_DATA: if (skRise) begin
          cnt <= cnt + 1'b1;
          if (lastData) state <= S_DONE;
        end
        S_LOAD:  state <= S_READ;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weLatch   <= 1'b0;
      busy      <= 1'b0;
      tmr       <= '0;
      progAll   <= 1'b0;
      progErase <= 1'b0;
    end else begin
      if (weSet) weLatch <= 1'b1;
      if (weClr) weLatch <= 1'b0;
      if (startProg) begin
        busy      <= 1'b1;
        tmr       <= TMR_W'(PROG_CYCLES - 1);
        progAll   <= nxtAll;
        progErase <= nxtErase;
      end else if (busy) begin
        if (tmr == '0) busy <= 1'b0;
        else tmr <= tmr - 1'b1;
      end
    end
  end
endmodule

// File: rtl/serialEepromData.sv
module serialEepromData
  import serialEepromPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  eeStrobes_t strb,
  output logic       outBit
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] dataReg;
  logic [DATA_W:0]   outReg;
  logic [DATA_W-1:0] wrWord;

  assign wrWord = strb.fillOnes ? {DATA_W{1'b1}} : dataReg;
  assign outBit = outReg[DATA_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
      outReg  <= '0;
    end else begin
      if (strb.shiftAddr) addrReg <= {addrReg[ADDR_W-2:0], strb.bitIn};
      if (strb.shiftData) dataReg <= {dataReg[DATA_W-2:0], strb.bitIn};
      if (strb.loadOut) outReg <= {1'b0, mem[addrReg]};
      else if (strb.shiftOut) outReg <= {outReg[DATA_W-1:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (strb.commit) begin
      if (strb.commitAll) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= wrWord;
      end else begin
        mem[addrReg] <= wrWord;
      end
    end
  end
endmodule

// File: rtl/serialEeprom.sv
module serialEeprom
  import serialEepromPkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 400
) (
  input  logic clk,
  input  logic rstN,
  input  logic csIn,
  input  logic skIn,
  input  logic diIn,
  output logic doOut,
  output logic doEn
);
  eeStrobes_t strb;
  logic busy, weLatch, pollActive, ctrlDoEn, outBit;

  serialEepromCtrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .csIn(csIn), .skIn(skIn), .diIn(diIn),
    .strb(strb), .busy(busy), .weLatch(weLatch),
    .pollActive(pollActive), .ctrlDoEn(ctrlDoEn)
  );

  serialEepromData #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .outBit(outBit)
  );

  assign doEn  = ctrlDoEn;
  assign doOut = doEn & (pollActive ? ~busy : outBit);
endmodule

// File: rtl/serialEepromChk.sv
module serialEepromChk (
  input logic clk,
  input logic rstN,
  input logic csIn,
  input logic doOut,
  input logic doEn,
  input logic busy,
  input logic weLatch,
  input logic commit
);
  p_off_when_cs_low_r11: assert property (@(posedge clk) disable iff (!rstN)
    !$past(csIn) |-> !doEn);
  p_quiet_when_off_r11: assert property (@(posedge clk) disable iff (!rstN)
    !doEn |-> !doOut);
  p_commit_needs_we_r3: assert property (@(posedge clk) disable iff (!rstN)
    commit |-> weLatch);
  p_busy_reads_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && doEn) |-> !doOut);
  p_commit_ends_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    commit |=> !busy);
  p_busy_ends_by_commit_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(commit));
endmodule

bind serialEeprom serialEepromChk u_chk (
  .clk(clk), .rstN(rstN), .csIn(csIn), .doOut(doOut), .doEn(doEn),
  .busy(busy), .weLatch(weLatch), .commit(strb.commit)
);

// File: tb/serialEeprom_bench.sv
module serialEeprom_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int PROG = 400;
  localparam int WAITP = PROG + 50;

  logic clk = 1'b0, rstN = 1'b0, csIn = 1'b0, skIn = 1'b0, diIn = 1'b0;
  logic doOut, doEn;
  int nChecks = 0, nFails = 0;
  logic [DW-1:0] model [1 << AW];
  logic modelWe = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  serialEeprom #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PROG)) u_serialEeprom (
    .clk(clk), .rstN(rstN), .csIn(csIn), .skIn(skIn), .diIn(diIn),
    .doOut(doOut), .doEn(doEn)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic b);
    diIn = b; tick(4); skIn = 1'b1; tick(4); skIn = 1'b0;
  endtask

  task automatic beginFrame(input logic [1:0] op, input logic [AW-1:0] addr, input int zeros);
    csIn = 1'b1; tick(2);
    for (int i = 0; i < zeros; i++) sendBit(1'b0);
    sendBit(1'b1);
    sendBit(op[1]); sendBit(op[0]);
    for (int i = AW - 1; i >= 0; i--) sendBit(addr[i]);
  endtask

  task automatic endFrame();
    csIn = 1'b0; diIn = 1'b0; tick(4);
  endtask

  task automatic sendWord(input logic [DW-1:0] w);
    for (int i = DW - 1; i >= 0; i--) sendBit(w[i]);
  endtask

  function automatic logic [AW-1:0] spec(input logic [1:0] g);
    return {g, {(AW - 2){1'b0}}};
  endfunction

  task automatic readCheck(input logic [AW-1:0] addr, input string req, input int zeros);
    logic [DW-1:0] w;
    logic dummy, en;
    beginFrame(2'b10, addr, zeros);
    tick(2);
    dummy = doOut; en = doEn;
    for (int i = 0; i < DW; i++) begin
      sendBit(1'b0); tick(2);
      w = {w[DW-2:0], doOut};
    end
    endFrame();
    check(en === 1'b1 && dummy === 1'b0, {req, " R2 dummy"}, {30'd0, en, dummy}, 32'd2);
    check(w === model[addr], req, {16'd0, w}, {16'd0, model[addr]});
  endtask

  task automatic waitProg(input bit poll);
    if (poll) begin
      csIn = 1'b1; tick(3);
      check(doEn === 1'b1 && doOut === 1'b0, "R8 busy", {30'd0, doEn, doOut}, 32'd2);
      tick(WAITP);
      check(doEn === 1'b1 && doOut === 1'b1, "R8 ready", {30'd0, doEn, doOut}, 32'd3);
      endFrame();
    end else tick(WAITP);
  endtask

  task automatic opWrite(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit poll);
    beginFrame(2'b01, a, 0); sendWord(d); endFrame();
    if (modelWe) begin model[a] = d; waitProg(poll); end
  endtask

  task automatic opErase(input logic [AW-1:0] a);
    beginFrame(2'b11, a, 0); endFrame();
    if (modelWe) begin model[a] = '1; waitProg(1'b0); end
  endtask

  task automatic opFill(input logic [DW-1:0] d);
    beginFrame(2'b00, spec(2'b01), 0); sendWord(d); endFrame();
    if (modelWe) begin
      for (int i = 0; i < (1 << AW); i++) model[i] = d;
      waitProg(1'b0);
    end
  endtask

  task automatic opEraseAll();
    beginFrame(2'b00, spec(2'b10), 0); endFrame();
    if (modelWe) begin
      for (int i = 0; i < (1 << AW); i++) model[i] = '1;
      waitProg(1'b0);
    end
  endtask

  task automatic opWe(input bit on);
    beginFrame(2'b00, spec(on ? 2'b11 : 2'b00), 0); endFrame();
    modelWe = on;
  endtask

  initial begin
    tick(20000 * 10);
    nFails++; nChecks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    logic [DW-1:0] rw;
    logic [AW-1:0] ra;
    int r;
    for (int i = 0; i < (1 << AW); i++) model[i] = '0;
    void'($urandom(32'd1234));
    tick(4); rstN = 1'b1; tick(4);

    check(doEn === 1'b0 && doOut === 1'b0, "R12 reset", {30'd0, doEn, doOut}, 32'd0);
    readCheck(6'd5, "R12 zero word", 0);

    // R3: programming refused while latch cleared; no status either
    beginFrame(2'b01, 6'd3, 0); sendWord(16'hBEEF); endFrame();
    csIn = 1'b1; tick(3);
    check(doEn === 1'b0, "R3 no busy", {31'd0, doEn}, 32'd0);
    endFrame();
    readCheck(6'd3, "R3 write ignored", 0);

    opWe(1'b1);
    opWrite(6'd3, 16'hA5C3, 1'b1);
    readCheck(6'd3, "R5 write stored", 0);

    opErase(6'd3);
    readCheck(6'd3, "R6 erase", 0);

    // R9: raise CS after the cycle ended -> no status
    opWrite(6'd7, 16'h0F0F, 1'b0);
    csIn = 1'b1; tick(3);
    check(doEn === 1'b0, "R9 late poll", {31'd0, doEn}, 32'd0);
    endFrame();
    readCheck(6'd7, "R5 second write", 0);

    // R10: frame sent during busy ignored
    beginFrame(2'b01, 6'd10, 0); sendWord(16'h1111); endFrame();
    beginFrame(2'b01, 6'd11, 0); sendWord(16'h2222); endFrame();
    model[10] = 16'h1111;
    tick(WAITP);
    readCheck(6'd11, "R10 ignored while busy", 0);
    readCheck(6'd10, "R10 first write", 0);

    // R11: abandoned write
    beginFrame(2'b01, 6'd9, 0);
    for (int i = 0; i < 8; i++) sendBit(1'b1);
    endFrame();
    tick(WAITP);
    readCheck(6'd9, "R11 aborted frame", 0);

    // R1: leading zeros before start bit
    beginFrame(2'b01, 6'd12, 3); sendWord(16'h5A5A); endFrame();
    model[12] = 16'h5A5A; tick(WAITP);
    readCheck(6'd12, "R1 leading zeros", 2);

    opFill(16'h1234);
    readCheck(6'd0, "R7 fill low", 0);
    readCheck(6'd63, "R7 fill high", 0);
    opEraseAll();
    readCheck(6'd17, "R7 erase all", 0);
    opWrite(6'd4, 16'h0042, 1'b0);

    opWe(1'b0);
    opWrite(6'd4, 16'h7777, 1'b0);
    readCheck(6'd4, "R4 disabled again", 0);
    opEraseAll();
    readCheck(6'd4, "R4 erase-all refused", 0);

    for (int n = 0; n < 60; n++) begin
      r = $urandom % 10;
      ra = AW'($urandom);
      rw = DW'($urandom);
      case (r)
        0, 1, 2, 3: readCheck(ra, "R2 random read", 0);
        4, 5: opWrite(ra, rw, 1'b0);
        6: opErase(ra);
        7: opWe(1'b1);
        8: opWe(1'b0);
        default: if ($urandom % 2 == 0) opFill(rw); else opEraseAll();
      endcase
    end
    readCheck(6'd0, "R2 final read", 0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule